// File: doc/BRIEF.md
# Crystal Clock Failure Detector

This block watches a fast crystal oscillator clock and reports when that clock runs too slowly or stops. A free-running slow RC clock is the time base. While the slow clock is high, a small counter in the crystal clock domain counts the crystal's rising edges. While the slow clock is low, the same counter is held at zero. At the end of each high phase, logic in the slow domain takes the count and decides whether the crystal passed or failed.

The detector runs only when software has enabled it and the crystal oscillator is itself switched on. After it starts, a short settling window must pass before its verdict counts. Once that window is over, it reports a fault level, a one-cycle pulse when a fault begins, and a flag that marks the status as valid. All of its outputs are registered in the slow clock domain, on rising edges of `clk_ref`.

The finite-state machine has four states:
- `ST_IDLE`: the detector is off.
- `ST_SETTLE`: the pipeline is filling.
- `ST_MONITOR`: the crystal is healthy.
- `ST_FAULT`: the crystal is failing.

Its transitions are:
- start: `ST_IDLE` to `ST_SETTLE`, when both `det_en` and `osc_on` are 1.
- settle-wait: `ST_SETTLE` stays in `ST_SETTLE` while the settle counter runs.
- settle-pass: `ST_SETTLE` to `ST_MONITOR`.
- settle-fail: `ST_SETTLE` to `ST_FAULT`.
- trip: `ST_MONITOR` to `ST_FAULT`.
- recover: `ST_FAULT` to `ST_MONITOR`.
- shutdown: any state to `ST_IDLE`, when `det_en` or `osc_on` is 0.

Top module: `xosc_fail_monitor`

## Requirements
- R1: While `rst_n` is low, and after reset until the detector is enabled, `status_valid`, `fail_level` and `fail_pulse` are all 0.
- R2: The detector runs only while `det_en` and `osc_on` are both 1. At the first `clk_ref` rising edge that sees either of them at 0, it returns to idle and all three outputs go to 0. It stays idle while either input is 0, whatever the other input says.
- R3: The edge counter counts rising edges of `clk_xtal` only while `clk_ref` is high and the detector runs. While `clk_ref` is low, it is held at zero.
- R4: A high phase of `clk_ref` that holds at least MIN_EDGES (default 8) rising edges of `clk_xtal` is a pass. Any smaller number, including zero from a stopped crystal, is a fail.
- R5: The edge counter saturates at MIN_EDGES and never wraps, however fast the crystal runs. A very fast crystal therefore always passes.
- R6: `status_valid` goes to 1 at the SETTLE_CYC-th (default 2nd) `clk_ref` rising edge after the edge that first samples both enables at 1. It is 0 before that edge.
- R7: If the high phase that starts at `clk_ref` rising edge k fails, `fail_level` is 1 after rising edge k+2. It is still 0 after edge k+1 if the detector was healthy before.
- R8: `fail_pulse` is 1 for exactly one `clk_ref` cycle: the cycle in which `fail_level` first becomes 1. This holds whether the fault begins during settling or during monitoring.
- R9: If the high phase that starts at rising edge k passes while a fault is shown, `fail_level` goes back to 0 after rising edge k+2.
- R10: The pass result crosses into the slow domain in two steps. A flop on the falling edge of `clk_ref` captures it, then a flop on the rising edge of `clk_ref` takes it over. The FSM acts only on the output of the second flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal oscillator clock under watch |
| clk_ref | input | 1 | Slow free-running RC reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detector enable, synchronous to clk_ref |
| osc_on | input | 1 | Crystal oscillator is switched on, synchronous to clk_ref |
| status_valid | output | 1 | The verdict is valid (monitor or fault state) |
| fail_level | output | 1 | The crystal is failing |
| fail_pulse | output | 1 | One-cycle pulse when a fault begins |

## Verification
The bench builds the block with its defaults, MIN_EDGES = 8 and SETTLE_CYC = 2. The reference high phase is 100 ns long, so crystal periods of 2 to 10 ns give at least 8 edges per phase and pass, while periods of 20 ns and more, or a stopped crystal, fail. A 2 ns period drives the counter deep into saturation. The short settle window lets the bench check the exact edge at which settling, detection and recovery take effect.

// File: rtl/xfm_pkg.sv
package xfm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_MONITOR = 2'd2,
        ST_FAULT   = 2'd3
    } xfm_state_e;
endpackage

// File: rtl/xfm_edge_counter.sv
// Crystal-domain edge counter; held at zero while gate is low (R3), saturating (R5)
module xfm_edge_counter #(
    parameter int MIN_EDGES = 8,
    parameter int CNT_W     = $clog2(MIN_EDGES + 1)
) (
    input  logic             clk_xtal,
    input  logic             gate,
    output logic [CNT_W-1:0] cnt,
    output logic             reached
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_EDGES);

    always_ff @(posedge clk_xtal or negedge gate) begin
        if (!gate) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign reached = (cnt == LIMIT);
endmodule

// File: rtl/xfm_result_sync.sv
// Two-step transfer of the pass flag into the slow domain (R10)
module xfm_result_sync (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic reached,
    output logic pass_sync
);
    logic pass_cap;

    always_ff @(negedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            pass_cap <= 1'b0;
        end else begin
            pass_cap <= reached;
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            pass_sync <= 1'b0;
        end else begin
            pass_sync <= pass_cap;
        end
    end
endmodule

// File: rtl/xfm_fsm.sv
module xfm_fsm
    import xfm_pkg::*;
#(
    parameter int SETTLE_CYC = 2,
    parameter int SET_W      = $clog2(SETTLE_CYC + 1)
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       det_en,
    input  logic       osc_on,
    input  logic       pass_sync,
    output xfm_state_e state,
    output logic       run,
    output logic       status_valid,
    output logic       fail_level,
    output logic       fail_pulse
);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    xfm_state_e       nxt;
    logic [SET_W-1:0] set_cnt;
    logic [SET_W-1:0] set_cnt_nxt;
    logic             active;

    assign active = det_en && osc_on;

    always_comb begin
        nxt         = state;
        set_cnt_nxt = set_cnt;
        unique case (state)
            ST_IDLE: begin
                set_cnt_nxt = '0;
                if (active) nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (!active) begin
                    nxt = ST_IDLE;
                end else if (set_cnt == SET_LAST) begin
                    nxt = pass_sync ? ST_MONITOR : ST_FAULT;
                end else begin
                    set_cnt_nxt = set_cnt + 1'b1;
                end
            end
            ST_MONITOR: begin
                if (!active)        nxt = ST_IDLE;
                else if (!pass_sync) nxt = ST_FAULT;
            end
            ST_FAULT: begin
                if (!active)       nxt = ST_IDLE;
                else if (pass_sync) nxt = ST_MONITOR;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            set_cnt    <= '0;
            fail_pulse <= 1'b0;
        end else begin
            state      <= nxt;
            set_cnt    <= (nxt == ST_IDLE) ? '0 : set_cnt_nxt;
            fail_pulse <= (nxt == ST_FAULT) && (state != ST_FAULT);
        end
    end

    always_comb begin
        run          = 1'b0;
        status_valid = 1'b0;
        fail_level   = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_SETTLE:  run = 1'b1;
            ST_MONITOR: begin
                run          = 1'b1;
                status_valid = 1'b1;
            end
            ST_FAULT: begin
                run          = 1'b1;
                status_valid = 1'b1;
                fail_level   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xosc_fail_monitor.sv
module xosc_fail_monitor
    import xfm_pkg::*;
#(
    parameter int MIN_EDGES  = 8,
    parameter int SETTLE_CYC = 2
) (
    input  logic clk_xtal,
    input  logic clk_ref,
    input  logic rst_n,
    input  logic det_en,
    input  logic osc_on,
    output logic status_valid,
    output logic fail_level,
    output logic fail_pulse
);
    localparam int CNT_W = $clog2(MIN_EDGES + 1);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    xfm_state_e       state;
    logic             run;
    logic             gate;
    logic [CNT_W-1:0] edge_cnt;
    logic             reached;
    logic             pass_sync;

    // Counter counts only while the reference is high and the detector runs
    assign gate = clk_ref & run;

    xfm_edge_counter #(.MIN_EDGES(MIN_EDGES), .CNT_W(CNT_W)) u_cnt (
        .clk_xtal (clk_xtal),
        .gate     (gate),
        .cnt      (edge_cnt),
        .reached  (reached)
    );

    xfm_result_sync u_sync (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .reached   (reached),
        .pass_sync (pass_sync)
    );

    xfm_fsm #(.SETTLE_CYC(SETTLE_CYC), .SET_W(SET_W)) u_fsm (
        .clk_ref      (clk_ref),
        .rst_n        (rst_n),
        .det_en       (det_en),
        .osc_on       (osc_on),
        .pass_sync    (pass_sync),
        .state        (state),
        .run          (run),
        .status_valid (status_valid),
        .fail_level   (fail_level),
        .fail_pulse   (fail_pulse)
    );
endmodule

// File: rtl/xosc_fail_monitor_chk.sv
module xosc_fail_monitor_chk #(
    parameter int MIN_EDGES = 8,
    parameter int CNT_W     = 4
) (
    input logic             clk_ref,
    input logic             clk_xtal,
    input logic             rst_n,
    input logic             det_en,
    input logic             osc_on,
    input logic             status_valid,
    input logic             fail_level,
    input logic             fail_pulse,
    input logic [CNT_W-1:0] edge_cnt
);
    // R2
    off_when_disabled_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !(det_en && osc_on) |=> (!status_valid && !fail_level && !fail_pulse));

    // R5
    cnt_saturates_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        edge_cnt <= CNT_W'(MIN_EDGES));

    // R8
    pulse_on_entry_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fail_pulse |-> (fail_level && !$past(fail_level)));

    // R8
    rise_has_pulse_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(fail_level) |-> fail_pulse);

    // R6
    valid_after_settle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(status_valid) |-> ($past(det_en && osc_on, 1) && $past(det_en && osc_on, 2)));
endmodule

bind xosc_fail_monitor xosc_fail_monitor_chk #(
    .MIN_EDGES (MIN_EDGES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk_ref      (clk_ref),
    .clk_xtal     (clk_xtal),
    .rst_n        (rst_n),
    .det_en       (det_en),
    .osc_on       (osc_on),
    .status_valid (status_valid),
    .fail_level   (fail_level),
    .fail_pulse   (fail_pulse),
    .edge_cnt     (edge_cnt)
);

// File: tb/xosc_fail_monitor_tb.sv
module xosc_fail_monitor_tb;
    logic clk_xtal = 1'b0;
    logic clk_ref  = 1'b0;
    logic rst_n;
    logic det_en;
    logic osc_on;
    logic status_valid;
    logic fail_level;
    logic fail_pulse;

    int xtal_half = 4;   // 125 MHz nominal crystal
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {half period in ns (8 bits), expected fail}
    localparam int NVEC = 7;
    localparam logic [8:0] VEC [NVEC] = '{
        {8'd4,  1'b0},
        {8'd1,  1'b0},
        {8'd5,  1'b0},
        {8'd10, 1'b1},
        {8'd0,  1'b1},
        {8'd25, 1'b1},
        {8'd3,  1'b0}
    };

    xosc_fail_monitor u_dut (
        .clk_xtal     (clk_xtal),
        .clk_ref      (clk_ref),
        .rst_n        (rst_n),
        .det_en       (det_en),
        .osc_on       (osc_on),
        .status_valid (status_valid),
        .fail_level   (fail_level),
        .fail_pulse   (fail_pulse)
    );

    always begin
        if (xtal_half == 0) #1;
        else begin
            #(xtal_half) clk_xtal = ~clk_xtal;
        end
    end

    initial begin
        #1;
        forever #100 clk_ref = ~clk_ref;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk_ref);
        #20;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        det_en = 1'b0;
        osc_on = 1'b1;
        edges(3);
        check("R1 valid in reset", status_valid, 0);
        check("R1 fail in reset", fail_level, 0);
        check("R1 pulse in reset", fail_pulse, 0);
        rst_n = 1'b1;
        edges(3);
        check("R1 R2 stays off while det_en low", status_valid, 0);

        // R6 settle window
        det_en = 1'b1;
        edges(1);
        check("R6 not valid after sampling edge", status_valid, 0);
        edges(1);
        check("R6 not valid after edge 1", status_valid, 0);
        edges(1);
        check("R6 valid after edge 2", status_valid, 1);
        check("R4 good crystal passes", fail_level, 0);

        // Vector walk: R3 R4 R5 R10
        for (int i = 0; i < NVEC; i++) begin
            xtal_half = int'(VEC[i][8:1]);
            edges(4);
            check($sformatf("R4 R5 vector %0d fail", i), fail_level, VEC[i][0]);
            check($sformatf("R3 R10 vector %0d valid", i), status_valid, 1);
        end

        // R7 latency and R8 pulse; crystal healthy now
        edges(2);
        check("R7 healthy before stop", fail_level, 0);
        xtal_half = 0;
        edges(1);
        check("R7 not yet failed at k+1", fail_level, 0);
        edges(1);
        check("R7 failed at k+2", fail_level, 1);
        check("R8 pulse on entry", fail_pulse, 1);
        edges(1);
        check("R8 pulse one cycle", fail_pulse, 0);
        check("R8 level held", fail_level, 1);

        // R9 recovery
        xtal_half = 4;
        edges(1);
        check("R9 still failed at k+1", fail_level, 1);
        edges(1);
        check("R9 recovered at k+2", fail_level, 0);

        // R2 oscillator off forces detector off
        xtal_half = 0;
        edges(4);
        check("R2 stopped crystal flagged", fail_level, 1);
        osc_on = 1'b0;
        edges(1);
        check("R2 osc off clears fail", fail_level, 0);
        check("R2 osc off clears valid", status_valid, 0);
        edges(3);
        check("R2 stays off with det_en high", status_valid, 0);
        osc_on    = 1'b1;
        xtal_half = 4;
        edges(3);
        check("R2 R6 restart valid", status_valid, 1);
        check("R2 restart passes", fail_level, 0);

        // R2 enable toggling restarts settling
        det_en = 1'b0;
        edges(1);
        check("R2 det_en low clears valid", status_valid, 0);
        det_en = 1'b1;
        edges(2);
        check("R6 settle restarted", status_valid, 0);
        edges(1);
        check("R6 valid after re-enable", status_valid, 1);

        // R8 fault found during settling
        det_en    = 1'b0;
        xtal_half = 0;
        edges(2);
        det_en = 1'b1;
        edges(2);
        check("R8 no pulse during settle", fail_pulse, 0);
        edges(1);
        check("R8 settle-fail level", fail_level, 1);
        check("R8 settle-fail pulse", fail_pulse, 1);
        edges(1);
        check("R8 settle-fail pulse ends", fail_pulse, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule